// File: doc/BRIEF.md
# Digital AGC Step Controller

This block closes the digital side of an automatic gain loop around a variable-gain read amplifier. Two level-detector flags tell it whether the amplified signal sits below or above its target window. From them it moves a 4-bit gain code one step (1 dB) at a time. Gain is raised slowly and lowered quickly. Each direction has its own prescaler, so an upward step needs a long run of "too small" cycles and a downward step needs only a short run of "too large" cycles. With the default counts at a 24 MHz clock, a full climb takes roughly 10 ms and a full descent roughly 0.2 ms.

The loop can be suspended in three ways, which never alter the configured values:
- It is frozen while a write is in progress, or while the hold pin is low in plain hold mode.
- A fixed-gain setting replaces it with a register value.
- In servo mode (hold-mode bit set and hold pin low) the output is forced to maximum gain.

When the loop resumes, it continues from the gain it held before. The block also decides which source feeds the variable-gain stage. It reports the live gain and a direction flag, and software reads both as status.

Top module: `agc_step_ctrl`

## Requirements
- R1: During and right after reset, `gain_out` is 0, `dir_flag` is 0 and the internal loop gain is 0.
- R2: While the loop runs, `too_small` is 1 and `too_large` is 0, the loop gain rises by one at the end of every UP_TICKS consecutive such cycles. A break in the request restarts the count.
- R3: While the loop runs and `too_large` is 1, the loop gain falls by one at the end of every DOWN_TICKS consecutive such cycles, whatever the value of `too_small`.
- R4: The loop gain saturates: it never goes below 0 or above 15, and it does not wrap.
- R5: When `cfg_fixed` is 1, `gain_out` equals `cfg_gain` regardless of servo, hold or write state, and the loop gain does not move.
- R6: Servo mode is active when `cfg_hold_mode` is 1 and `hold_n` is 0. In servo mode (with `cfg_fixed` 0), `gain_out` is 15 and the loop gain does not move.
- R7: When `cfg_hold_mode` is 0 and `hold_n` is 0, or when `write_active` is 1, the loop gain is frozen and `gain_out` shows it.
- R8: After freeze, servo or fixed mode ends, `gain_out` returns to the loop gain held before, and stepping continues from there.
- R9: `src_sel` is 00 (servo preamplifier) in servo mode. Otherwise it equals `cfg_src`, coded as 00 servo preamplifier, 01 data preamplifier, 10 bias output at -10 dB, 11 bias output at -4 dB.
- R10: `dir_flag` is the value of `too_large` registered one clock earlier: 1 means gain may be decreased, 0 means it may be increased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| too_small | input | 1 | Level detector: output below window |
| too_large | input | 1 | Level detector: output above window |
| hold_n | input | 1 | Hold pin, active low |
| write_active | input | 1 | Write in progress, freezes the loop |
| cfg_hold_mode | input | 1 | 0: hold pin freezes; 1: hold pin selects servo mode |
| cfg_fixed | input | 1 | Use `cfg_gain` instead of the loop |
| cfg_gain | input | GAIN_W | Fixed gain code |
| cfg_src | input | 2 | Configured variable-gain input source |
| gain_out | output | GAIN_W | Gain code applied and reported as status |
| dir_flag | output | 1 | Direction flag for status |
| src_sel | output | 2 | Selected variable-gain input source |

## Verification
A miscounting prescaler shows at `gain_out` as a step one or more cycles early or late relative to an uninterrupted request run. This is visible within one step interval. A loop register that drifts during an override stays hidden while servo or fixed mode masks it. It surfaces on the first cycle after the override drops, as a gain different from the one held before. A wrong mode decode is seen on the same cycle, as a wrong `src_sel` or a gain that is not forced.

// File: rtl/agc_pkg.sv
package agc_pkg;

  typedef enum logic [1:0] {
    SRC_SERVO_PRE = 2'b00,
    SRC_DATA_PRE  = 2'b01,
    SRC_BIAS_M10  = 2'b10,
    SRC_BIAS_M4   = 2'b11
  } agc_src_e;

  typedef struct packed {
    logic fixed;
    logic servo;
    logic freeze;
    logic run;
  } agc_mode_t;

endpackage

// File: rtl/agc_mode_decode.sv
module agc_mode_decode
  import agc_pkg::*;
(
  input  logic      hold_n,
  input  logic      write_active,
  input  logic      cfg_hold_mode,
  input  logic      cfg_fixed,
  input  logic [1:0] cfg_src,
  output agc_mode_t mode,
  output agc_src_e  src
);

  logic hold_low;
  assign hold_low = ~hold_n;

  always_comb begin
    mode.fixed  = cfg_fixed;
    mode.servo  = cfg_hold_mode & hold_low;
    mode.freeze = (~cfg_hold_mode & hold_low) | write_active;
    mode.run    = ~mode.fixed & ~mode.servo & ~mode.freeze;
  end

  always_comb begin
    if (mode.servo) src = SRC_SERVO_PRE;
    else            src = agc_src_e'(cfg_src);
  end

endmodule

// File: rtl/agc_prescaler.sv
module agc_prescaler #(
  parameter int TICKS = 320
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic tick
);

  localparam int CW = (TICKS > 2) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  assign tick = req && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!req) cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/agc_gain_track.sv
module agc_gain_track #(
  parameter int GAIN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_tick,
  input  logic              dn_tick,
  output logic [GAIN_W-1:0] gain
);

  localparam logic [GAIN_W-1:0] GMAX = '1;

  function automatic logic [GAIN_W-1:0] sat_up(input logic [GAIN_W-1:0] g);
    return (g == GMAX) ? g : g + 1'b1;
  endfunction

  function automatic logic [GAIN_W-1:0] sat_down(input logic [GAIN_W-1:0] g);
    return (g == '0) ? g : g - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gain <= '0;
    else if (dn_tick) gain <= sat_down(gain);
    else if (up_tick) gain <= sat_up(gain);
  end

endmodule

// File: rtl/agc_step_ctrl.sv
module agc_step_ctrl
  import agc_pkg::*;
#(
  parameter int GAIN_W     = 4,
  parameter int UP_TICKS   = 16000,
  parameter int DOWN_TICKS = 320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              too_small,
  input  logic              too_large,
  input  logic              hold_n,
  input  logic              write_active,
  input  logic              cfg_hold_mode,
  input  logic              cfg_fixed,
  input  logic [GAIN_W-1:0] cfg_gain,
  input  logic [1:0]        cfg_src,
  output logic [GAIN_W-1:0] gain_out,
  output logic              dir_flag,
  output logic [1:0]        src_sel
);

  localparam logic [GAIN_W-1:0] GMAX = '1;

  agc_mode_t         mode;
  agc_src_e          src;
  logic              servo_on;
  logic              loop_run;
  logic              up_req;
  logic              dn_req;
  logic              up_tick;
  logic              dn_tick;
  logic [GAIN_W-1:0] loop_gain;

  function automatic logic [GAIN_W-1:0] pick_gain(
    input agc_mode_t         m,
    input logic [GAIN_W-1:0] fixed_val,
    input logic [GAIN_W-1:0] loop_val
  );
    if (m.fixed)      return fixed_val;
    else if (m.servo) return GMAX;
    else              return loop_val;
  endfunction

  agc_mode_decode u_mode (
    .hold_n       (hold_n),
    .write_active (write_active),
    .cfg_hold_mode(cfg_hold_mode),
    .cfg_fixed    (cfg_fixed),
    .cfg_src      (cfg_src),
    .mode         (mode),
    .src          (src)
  );

  assign servo_on = mode.servo;
  assign loop_run = mode.run;
  assign dn_req   = loop_run & too_large;
  assign up_req   = loop_run & too_small & ~too_large;

  agc_prescaler #(.TICKS(UP_TICKS)) u_up_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (up_req),
    .tick (up_tick)
  );

  agc_prescaler #(.TICKS(DOWN_TICKS)) u_dn_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (dn_req),
    .tick (dn_tick)
  );

  agc_gain_track #(.GAIN_W(GAIN_W)) u_gain (
    .clk    (clk),
    .rst_n  (rst_n),
    .up_tick(up_tick),
    .dn_tick(dn_tick),
    .gain   (loop_gain)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_flag <= 1'b0;
    else        dir_flag <= too_large;
  end

  assign gain_out = pick_gain(mode, cfg_gain, loop_gain);
  assign src_sel  = src;

endmodule

// File: rtl/agc_step_ctrl_chk.sv
module agc_step_ctrl_chk #(
  parameter int GAIN_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              too_large,
  input logic              cfg_fixed,
  input logic [GAIN_W-1:0] cfg_gain,
  input logic [GAIN_W-1:0] gain_out,
  input logic              dir_flag,
  input logic [1:0]        src_sel,
  input logic              servo_on,
  input logic              loop_run,
  input logic              up_tick,
  input logic              dn_tick,
  input logic [GAIN_W-1:0] loop_gain
);

  localparam logic [GAIN_W-1:0] GMAX = '1;

  // R2
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_tick && !dn_tick && loop_gain != GMAX) |=> (loop_gain == $past(loop_gain) + 1'b1));

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_tick && loop_gain != '0) |=> (loop_gain == $past(loop_gain) - 1'b1));

  // R4
  ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_gain == GMAX && !dn_tick) |=> (loop_gain == GMAX));

  // R4
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_gain == '0 && !up_tick) |=> (loop_gain == '0));

  // R7
  frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_run |=> $stable(loop_gain));

  // R6
  servo_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (servo_on && !cfg_fixed) |-> (gain_out == GMAX));

  // R9
  servo_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    servo_on |-> (src_sel == 2'b00));

  // R5
  fixed_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fixed |-> (gain_out == cfg_gain));

  // R8
  loop_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_run |-> (gain_out == loop_gain));

  // R10
  dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    too_large |=> dir_flag);

  // R10
  dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !too_large |=> !dir_flag);

endmodule

bind agc_step_ctrl agc_step_ctrl_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .too_large(too_large),
  .cfg_fixed(cfg_fixed),
  .cfg_gain (cfg_gain),
  .gain_out (gain_out),
  .dir_flag (dir_flag),
  .src_sel  (src_sel),
  .servo_on (servo_on),
  .loop_run (loop_run),
  .up_tick  (up_tick),
  .dn_tick  (dn_tick),
  .loop_gain(loop_gain)
);

// File: tb/agc_step_ctrl_tb.sv
`timescale 1ns/1ps
module agc_step_ctrl_tb;

  localparam int GW   = 4;
  localparam int UP   = 20;
  localparam int DN   = 4;
  localparam int GTOP = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          too_small = 1'b0, too_large = 1'b0, hold_n = 1'b1, write_active = 1'b0;
  logic          cfg_hold_mode = 1'b0, cfg_fixed = 1'b0;
  logic [GW-1:0] cfg_gain = '0;
  logic [1:0]    cfg_src = 2'b01;
  logic [GW-1:0] gain_out;
  logic          dir_flag;
  logic [1:0]    src_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench reference state
  int m_gain = 0, m_up = 0, m_dn = 0;
  bit m_dir = 0;

  always #4 clk = ~clk;

  agc_step_ctrl #(.GAIN_W(GW), .UP_TICKS(UP), .DOWN_TICKS(DN)) u_dut (
    .clk(clk), .rst_n(rst_n), .too_small(too_small), .too_large(too_large),
    .hold_n(hold_n), .write_active(write_active), .cfg_hold_mode(cfg_hold_mode),
    .cfg_fixed(cfg_fixed), .cfg_gain(cfg_gain), .cfg_src(cfg_src),
    .gain_out(gain_out), .dir_flag(dir_flag), .src_sel(src_sel)
  );

  function automatic bit in_servo();
    return cfg_hold_mode && !hold_n;
  endfunction

  function automatic bit in_freeze();
    return (!cfg_hold_mode && !hold_n) || write_active;
  endfunction

  function automatic int exp_gain();
    if (cfg_fixed) return int'(cfg_gain);
    if (in_servo()) return GTOP;
    return m_gain;
  endfunction

  function automatic int exp_src();
    return in_servo() ? 0 : int'(cfg_src);
  endfunction

  // reference update, inputs are stable at the rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_gain = 0; m_up = 0; m_dn = 0; m_dir = 0;
    end else begin
      bit run;
      run = !cfg_fixed && !in_servo() && !in_freeze();
      if (run && too_large) begin
        if (m_dn == DN - 1) begin m_dn = 0; if (m_gain > 0) m_gain = m_gain - 1; end
        else m_dn = m_dn + 1;
      end else m_dn = 0;
      if (run && too_small && !too_large) begin
        if (m_up == UP - 1) begin m_up = 0; if (m_gain < GTOP) m_gain = m_gain + 1; end
        else m_up = m_up + 1;
      end else m_up = 0;
      m_dir = too_large;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle, then compare every output with the reference
  task automatic cyc();
    @(negedge clk);
    chk(int'(gain_out) == exp_gain(), "R2 gain", int'(gain_out), exp_gain());
    chk(dir_flag == m_dir, "R10 dir", int'(dir_flag), int'(m_dir));
    chk(int'(src_sel) == exp_src(), "R9 src", int'(src_sel), exp_src());
  endtask

  task automatic run_n(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(gain_out == 0, "R1 gain", int'(gain_out), 0);
    chk(dir_flag == 0, "R1 dir", int'(dir_flag), 0);
    rst_n = 1'b1;
    cyc();
    chk(gain_out == 0, "R1 gain after release", int'(gain_out), 0);

    // R9 source pass-through
    for (int v = 0; v < 4; v++) begin
      cfg_src = 2'(v);
      cyc();
      chk(int'(src_sel) == v, "R9 pass", int'(src_sel), v);
    end
    cfg_src = 2'b01;

    // R2 exact up-step timing
    too_small = 1'b1;
    run_n(UP - 1);
    chk(gain_out == 0, "R2 early", int'(gain_out), 0);
    cyc();
    chk(gain_out == 1, "R2 step", int'(gain_out), 1);
    // R2 break restarts count
    too_small = 1'b0; cyc();
    too_small = 1'b1; run_n(UP - 1);
    chk(gain_out == 1, "R2 restart", int'(gain_out), 1);
    cyc();
    chk(gain_out == 2, "R2 restart step", int'(gain_out), 2);
    // R4 climb and saturate
    run_n(UP * 13);
    chk(gain_out == 15, "R4 top", int'(gain_out), 15);
    run_n(UP * 2);
    chk(gain_out == 15, "R4 no wrap up", int'(gain_out), 15);

    // R3 down step wins over too_small
    too_large = 1'b1;
    run_n(DN - 1);
    chk(gain_out == 15, "R3 early", int'(gain_out), 15);
    cyc();
    chk(gain_out == 14, "R3 step", int'(gain_out), 14);
    chk(dir_flag == 1, "R10 set", int'(dir_flag), 1);
    run_n(DN * 16);
    chk(gain_out == 0, "R4 no wrap down", int'(gain_out), 0);

    // climb to 5
    too_large = 1'b0;
    cyc();
    chk(dir_flag == 0, "R10 clear", int'(dir_flag), 0);
    run_n(UP * 5 - 1);
    chk(gain_out == 5, "R2 reach 5", int'(gain_out), 5);

    // R7 freeze by hold pin
    too_small = 1'b0; too_large = 1'b1; hold_n = 1'b0;
    run_n(DN * 5);
    chk(gain_out == 5, "R7 hold freeze", int'(gain_out), 5);
    // R7 freeze by write
    hold_n = 1'b1; write_active = 1'b1;
    run_n(DN * 5);
    chk(gain_out == 5, "R7 write freeze", int'(gain_out), 5);
    write_active = 1'b0; too_large = 1'b0;

    // R6 servo override
    cfg_hold_mode = 1'b1; hold_n = 1'b0; cfg_src = 2'b10; too_large = 1'b1;
    cyc();
    chk(gain_out == 15, "R6 servo max", int'(gain_out), 15);
    chk(src_sel == 2'b00, "R9 servo src", int'(src_sel), 0);
    run_n(DN * 5);
    // R8 resume
    hold_n = 1'b1; too_large = 1'b0;
    cyc();
    chk(gain_out == 5, "R8 resume servo", int'(gain_out), 5);
    chk(src_sel == 2'b10, "R9 src back", int'(src_sel), 2);

    // R5 fixed gain over servo
    cfg_fixed = 1'b1; cfg_gain = 4'd9; hold_n = 1'b0; too_small = 1'b1;
    cyc();
    chk(gain_out == 9, "R5 fixed", int'(gain_out), 9);
    run_n(UP * 3);
    cfg_fixed = 1'b0; hold_n = 1'b1; too_small = 1'b0;
    cyc();
    chk(gain_out == 5, "R8 resume fixed", int'(gain_out), 5);
    cfg_hold_mode = 1'b0;

    // constrained random phase
    void'($urandom(32'h5eed_a6c1));
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      too_large    = (r < 20);
      too_small    = ($urandom_range(0, 99) < 70);
      hold_n       = ($urandom_range(0, 99) >= 8);
      write_active = ($urandom_range(0, 99) < 5);
      if ($urandom_range(0, 99) < 2) cfg_hold_mode = ~cfg_hold_mode;
      if ($urandom_range(0, 99) < 2) cfg_fixed = ~cfg_fixed;
      if ($urandom_range(0, 99) < 3) cfg_gain = GW'($urandom_range(0, 15));
      if ($urandom_range(0, 99) < 3) cfg_src = 2'($urandom_range(0, 3));
      run_n($urandom_range(1, 6));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule